// File: doc/BRIEF.md
# I2C Controller Register and FIFO Front End

This block is the software-visible face of an I2C master. A 32-bit register bus (address, write strobe, read strobe, write data, combinational read data) reaches a set of control and status registers and two byte FIFOs, one for outgoing and one for incoming bytes. The bit engine that drives SCL and SDA sits behind it. That engine pops transmit bytes, pushes received bytes, reads the latched command word, divider, target address and byte count, and reports its events back through single-cycle pulses and a bus-busy level.

Software loads the divider, the target address and the byte count. It fills the transmit FIFO and writes the command word while the controller is enabled. It then waits on the interrupt line, which rises once the engine reports completion or a NACK. Status flags are sticky. Most of them are cleared by writing 1 to the flag. The FIFOs are emptied by reset requests that clear themselves one cycle after they are written.

Top module: `i2c_csr_fifo`

## Requirements
- R1: After reset, every register reads 0, both FIFOs are empty (`tx_empty` high), `irq` is low and `cmd_start` is low.
- R2: Offset 0x00 stores bus release (bit 1), bus condition (bits 3:2), interrupt enable (bit 5) and controller enable (bit 7). These drive `ctl_release`, `ctl_cond`, `ctl_enable` and the interrupt gating. All other bits read 0.
- R3: Offset 0x04 keeps only bits 7:0 of the written word and drives `clk_div`. It changes only when written.
- R4: A write to 0x10 pushes bits 7:0 into a 16-entry transmit FIFO. The engine pops these bytes in order through `tx_pop` and `tx_byte`. A push into a full FIFO or a pop from an empty one is ignored. At offset 0x20, bits 23:16 give the transmit level and bit 5 is set when the FIFO is full.
- R5: `rx_push` stores `rx_byte` into a 16-entry receive FIFO, and a push into a full FIFO is ignored. A read of 0x14 pops one byte and returns it in bits 7:0. On an empty FIFO that read returns 0 and changes nothing. At offset 0x20, bits 15:8 give the receive level and bit 2 is set when the FIFO is not empty.
- R6: At offset 0x1C, bit 0 is ignore-NACK, held and driven on `nack_ignore`. Writing 1 to bit 1 resets the receive FIFO and writing 1 to bit 2 resets the transmit FIFO. Each reset bit reads back 1 for one cycle, after which the FIFO is empty and the bit reads 0.
- R7: At offset 0x20, bit 0 (done) is set by `ev_done` and bit 1 (NACK) by `ev_nack`. Both flags stay set until 1 is written to them. If an event and its clear arrive in the same cycle, the event wins.
- R8: At offset 0x08, bus error (bit 1, from `ev_buserr`) and arbitration lost (bit 3, from `ev_arblost`) are sticky, and bit 6 follows `ev_busy` live. Writing 1 clears bit 1 or bit 2. Writing the word 0 clears bits 1, 2 and 3. Writing 1 to bit 3 alone leaves it set.
- R9: Interrupt pending (offset 0x08, bit 2) is set by `ev_done` or `ev_nack`. `irq` is high exactly when both pending and interrupt enable are set.
- R10: While enabled, a write to 0x18 latches bits 15:0 into `cmd_word` and raises `cmd_start` for one cycle. While disabled, that write is ignored, and `cmd_word` is held at 0 from the cycle after enable drops.
- R11: Offset 0x0C (target address) and 0x24 (byte count) each keep bits 7:0. Offset 0x28 counts bytes accepted into the receive FIFO, and any accepted command write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX at 0x14) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while `reg_rd` is high |
| tx_pop | input | 1 | Engine takes the head transmit byte |
| tx_byte | output | 8 | Head transmit byte (0 when empty) |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| ev_done | input | 1 | Command-complete pulse |
| ev_nack | input | 1 | NACK-received pulse |
| ev_buserr | input | 1 | Bus-error pulse |
| ev_arblost | input | 1 | Arbitration-lost pulse |
| ev_busy | input | 1 | Bus busy level |
| ctl_enable | output | 1 | Controller enable |
| ctl_release | output | 1 | Bus release request |
| ctl_cond | output | 2 | Bus condition: 0 none, 1 start, 2 stop, 3 repeated start |
| nack_ignore | output | 1 | Continue past NACK |
| clk_div | output | 8 | Clock divider |
| tgt_addr | output | 8 | Target address byte |
| xfer_count | output | 8 | Byte count |
| cmd_word | output | 16 | Latched command word |
| cmd_start | output | 1 | One-cycle command launch pulse |
| irq | output | 1 | Interrupt request |

## Verification
Register storage is tried with all-ones and mixed patterns, so that stored bits can be told apart from bits that must read 0. The FIFOs are filled past capacity with ascending byte patterns. This shows ordering, the level fields and the dropped seventeenth push, and empty pops are issued on both sides. The flag tests pulse each event on its own, so that each event can be linked to the bit and the pending state it sets. They also pair a clear with a set in the same cycle and compare write-one clears with the write-zero clear-all. The command tests compare writes made while the controller is enabled and while it is disabled.

// File: rtl/i2c_csr_fifo.sv
module i2c_csr_fifo #(
  parameter int DEPTH = 16,
  parameter int DW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_empty,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        ev_done,
  input  logic        ev_nack,
  input  logic        ev_buserr,
  input  logic        ev_arblost,
  input  logic        ev_busy,
  output logic        ctl_enable,
  output logic        ctl_release,
  output logic [1:0]  ctl_cond,
  output logic        nack_ignore,
  output logic [7:0]  clk_div,
  output logic [7:0]  tgt_addr,
  output logic [7:0]  xfer_count,
  output logic [15:0] cmd_word,
  output logic        cmd_start,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [7:0] A_CTL = 8'h00, A_DIV = 8'h04, A_STS = 8'h08, A_TGT = 8'h0C;
  localparam logic [7:0] A_TXD = 8'h10, A_RXD = 8'h14, A_CMD = 8'h18, A_FCTL = 8'h1C;
  localparam logic [7:0] A_FSTS = 8'h20, A_CNT = 8'h24, A_RCNT = 8'h28;

  logic          ctl_ien, be_q, pend_q, arb_q, done_q, nack_q, rx_rst_q, tx_rst_q;
  logic [7:0]    rcnt_q;
  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire wr_ctl  = reg_wr && reg_addr == A_CTL;
  wire wr_div  = reg_wr && reg_addr == A_DIV;
  wire wr_sts  = reg_wr && reg_addr == A_STS;
  wire wr_cmd  = reg_wr && reg_addr == A_CMD && ctl_enable;
  wire wr_fctl = reg_wr && reg_addr == A_FCTL;
  wire wr_fsts = reg_wr && reg_addr == A_FSTS;
  wire sts_zero = wr_sts && reg_wdata == 32'd0;

  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire rx_avail = rx_cnt != '0;
  wire tx_in    = reg_wr && reg_addr == A_TXD && !tx_full;
  wire tx_out   = tx_pop && !tx_empty;
  wire rx_in    = rx_push && rx_cnt != CW'(DEPTH);
  wire rx_out   = reg_rd && reg_addr == A_RXD && rx_avail;

  assign tx_empty = tx_cnt == '0;
  assign tx_byte  = tx_empty ? 8'd0 : tx_mem[tx_rp];
  assign irq      = ctl_ien & pend_q;

  always_ff @(posedge clk) if (tx_in) tx_mem[tx_wp] <= reg_wdata[DW-1:0];
  always_ff @(posedge clk) if (rx_in) rx_mem[rx_wp] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_rst_q) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_in) tx_wp <= tx_wp + 1'b1;
      if (tx_out) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_in) - CW'(tx_out);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_rst_q) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_in) rx_wp <= rx_wp + 1'b1;
      if (rx_out) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_out);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_enable <= 1'b0; ctl_release <= 1'b0; ctl_cond <= 2'd0; ctl_ien <= 1'b0;
      clk_div <= '0; tgt_addr <= '0; xfer_count <= '0; rcnt_q <= '0;
      cmd_word <= '0; cmd_start <= 1'b0;
      nack_ignore <= 1'b0; rx_rst_q <= 1'b0; tx_rst_q <= 1'b0;
      be_q <= 1'b0; pend_q <= 1'b0; arb_q <= 1'b0; done_q <= 1'b0; nack_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctl_release <= reg_wdata[1];
        ctl_cond    <= reg_wdata[3:2];
        ctl_ien     <= reg_wdata[5];
        ctl_enable  <= reg_wdata[7];
      end
      if (wr_div) clk_div <= reg_wdata[7:0];
      if (reg_wr && reg_addr == A_TGT) tgt_addr <= reg_wdata[7:0];
      if (reg_wr && reg_addr == A_CNT) xfer_count <= reg_wdata[7:0];
      if (!ctl_enable) cmd_word <= '0;
      else if (wr_cmd) cmd_word <= reg_wdata[15:0];
      cmd_start <= wr_cmd;
      if (wr_cmd) rcnt_q <= '0;
      else if (rx_in) rcnt_q <= rcnt_q + 8'd1;
      if (wr_fctl) begin
        nack_ignore <= reg_wdata[0];
        rx_rst_q    <= reg_wdata[1];
        tx_rst_q    <= reg_wdata[2];
      end else begin
        rx_rst_q <= 1'b0;
        tx_rst_q <= 1'b0;
      end
      be_q   <= ev_buserr | (be_q & ~(wr_sts & (reg_wdata[1] | sts_zero)));
      pend_q <= ev_done | ev_nack | (pend_q & ~(wr_sts & (reg_wdata[2] | sts_zero)));
      arb_q  <= ev_arblost | (arb_q & ~sts_zero);
      done_q <= ev_done | (done_q & ~(wr_fsts & reg_wdata[0]));
      nack_q <= ev_nack | (nack_q & ~(wr_fsts & reg_wdata[1]));
    end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd)
      unique case (reg_addr)
        A_CTL:  reg_rdata = {24'd0, ctl_enable, 1'b0, ctl_ien, 1'b0, ctl_cond, ctl_release, 1'b0};
        A_DIV:  reg_rdata = {24'd0, clk_div};
        A_STS:  reg_rdata = {25'd0, ev_busy, 2'd0, arb_q, pend_q, be_q, 1'b0};
        A_TGT:  reg_rdata = {24'd0, tgt_addr};
        A_RXD:  reg_rdata = {24'd0, rx_avail ? rx_mem[rx_rp] : 8'd0};
        A_CMD:  reg_rdata = {16'd0, cmd_word};
        A_FCTL: reg_rdata = {29'd0, tx_rst_q, rx_rst_q, nack_ignore};
        A_FSTS: reg_rdata = {8'd0, 8'(tx_cnt), 8'(rx_cnt), 2'd0, tx_full, 2'd0, rx_avail, nack_q, done_q};
        A_CNT:  reg_rdata = {24'd0, xfer_count};
        A_RCNT: reg_rdata = {24'd0, rcnt_q};
        default: reg_rdata = '0;
      endcase
  end

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(DEPTH)); // R4
  AST_RX_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && !rx_push) |=> rx_cnt == '0); // R5
  AST_RST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rst_q && !wr_fctl) |=> (!rx_rst_q && rx_cnt == '0)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (done_q && pend_q)); // R7
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_div |=> $stable(clk_div)); // R3
  AST_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> (cmd_word == '0 && !cmd_start)); // R10
endmodule

// File: tb/i2c_csr_fifo_test.sv
module i2c_csr_fifo_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic tx_pop = 1'b0, tx_empty, rx_push = 1'b0;
  logic [7:0] tx_byte, rx_byte = '0;
  logic ev_done = 1'b0, ev_nack = 1'b0, ev_buserr = 1'b0, ev_arblost = 1'b0, ev_busy = 1'b0;
  logic ctl_enable, ctl_release, nack_ignore, cmd_start, irq;
  logic [1:0] ctl_cond;
  logic [7:0] clk_div, tgt_addr, xfer_count;
  logic [15:0] cmd_word;
  int checks = 0, errors = 0;
  logic [31:0] d;

  always #5 clk = ~clk;

  i2c_csr_fifo uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_pop(tx_pop), .tx_byte(tx_byte),
    .tx_empty(tx_empty), .rx_push(rx_push), .rx_byte(rx_byte), .ev_done(ev_done),
    .ev_nack(ev_nack), .ev_buserr(ev_buserr), .ev_arblost(ev_arblost), .ev_busy(ev_busy),
    .ctl_enable(ctl_enable), .ctl_release(ctl_release), .ctl_cond(ctl_cond),
    .nack_ignore(nack_ignore), .clk_div(clk_div), .tgt_addr(tgt_addr),
    .xfer_count(xfer_count), .cmd_word(cmd_word), .cmd_start(cmd_start), .irq(irq));

  // {is_read, offset, write data, expected read}
  localparam logic [72:0] VEC [10] = '{
    {1'b0, 8'h00, 32'hFFFF_FFFF, 32'h0},    // R2
    {1'b1, 8'h00, 32'h0, 32'h0000_00AE},    // R2
    {1'b0, 8'h04, 32'h1234_5678, 32'h0},    // R3
    {1'b1, 8'h04, 32'h0, 32'h0000_0078},    // R3
    {1'b0, 8'h0C, 32'hABCD_EF5A, 32'h0},    // R11
    {1'b1, 8'h0C, 32'h0, 32'h0000_005A},    // R11
    {1'b0, 8'h24, 32'h0000_01F0, 32'h0},    // R11
    {1'b1, 8'h24, 32'h0, 32'h0000_00F0},    // R11
    {1'b0, 8'h00, 32'h0000_0084, 32'h0},    // R2
    {1'b1, 8'h00, 32'h0, 32'h0000_0084}     // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic push_rx(input logic [7:0] b);
    rx_byte = b; rx_push = 1'b1; @(negedge clk); rx_push = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdchk("R1 ctl", 8'h00, 0); rdchk("R1 sts", 8'h08, 0); rdchk("R1 fsts", 8'h20, 0);
    rdchk("R1 rcnt", 8'h28, 0);
    chk("R1 irq/tx_empty/cmd_start", {irq, tx_empty, cmd_start}, 3'b010);

    for (int i = 0; i < 10; i++) begin
      if (VEC[i][72]) begin
        rd(VEC[i][71:64], d);
        chk($sformatf("table row %0d", i), d, VEC[i][31:0]);
      end else wr(VEC[i][71:64], VEC[i][63:32]);
    end
    chk("R2 ports", {ctl_enable, ctl_release, ctl_cond}, 4'b1001);
    chk("R3 clk_div", clk_div, 8'h78);
    chk("R11 ports", {tgt_addr, xfer_count}, 16'h5AF0);

    // R4 transmit FIFO
    for (int i = 0; i < 17; i++) wr(8'h10, 32'hFFFF_FF40 + i);
    rdchk("R4 full level", 8'h20, 32'h0010_0020);
    for (int i = 0; i < 16; i++) begin
      chk("R4 order", tx_byte, 8'h40 + i);
      tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
    end
    chk("R4 empty", tx_empty, 1'b1);
    tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
    rdchk("R4 empty pop ignored", 8'h20, 0);

    // R5 receive FIFO
    rdchk("R5 empty read", 8'h14, 0);
    rdchk("R5 empty read no change", 8'h20, 0);
    for (int i = 0; i < 17; i++) push_rx(8'h80 + i);
    rdchk("R5 full level", 8'h20, 32'h0000_1004);
    rdchk("R11 rcnt", 8'h28, 32'd16);
    for (int i = 0; i < 16; i++) rdchk("R5 order", 8'h14, 32'h80 + i);
    rdchk("R5 drained", 8'h14, 0);

    // R10 command while enabled
    wr(8'h18, 32'hDEAD_9C0F);
    chk("R10 start pulse", {cmd_start, cmd_word}, {1'b1, 16'h9C0F});
    @(negedge clk);
    chk("R10 pulse one cycle", cmd_start, 1'b0);
    rdchk("R10 cmd read", 8'h18, 32'h9C0F);
    rdchk("R11 rcnt cleared", 8'h28, 0);
    wr(8'h00, 0);
    @(negedge clk);
    chk("R10 disable clears", cmd_word, 16'h0);
    wr(8'h18, 32'h1111);
    chk("R10 disabled write ignored", {cmd_start, cmd_word}, 17'h0);

    // R6 FIFO resets
    for (int i = 0; i < 3; i++) wr(8'h10, i);
    wr(8'h1C, 32'h5);
    rdchk("R6 tx reset visible", 8'h1C, 32'h5);
    rdchk("R6 tx reset done", 8'h1C, 32'h1);
    chk("R6 nack_ignore", {nack_ignore, tx_empty}, 2'b11);
    rdchk("R6 tx level zero", 8'h20, 0);
    push_rx(8'h11); push_rx(8'h22);
    wr(8'h1C, 32'h2);
    @(negedge clk);
    rdchk("R6 rx emptied", 8'h20, 0);
    rdchk("R6 bits clear", 8'h1C, 0);

    // R7 / R9 done, nack, pending, irq
    wr(8'h00, 32'hA0);
    ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
    chk("R9 irq on done", irq, 1'b1);
    rdchk("R7 done flag", 8'h20, 32'h1);
    wr(8'h20, 32'h1);
    rdchk("R7 done cleared", 8'h20, 0);
    chk("R9 irq held", irq, 1'b1);
    wr(8'h08, 32'h4);
    chk("R9 irq cleared", irq, 1'b0);
    ev_nack = 1'b1; @(negedge clk); ev_nack = 1'b0;
    rdchk("R7 nack flag", 8'h20, 32'h2);
    rdchk("R9 pending on nack", 8'h08, 32'h4);
    wr(8'h08, 0);
    chk("R9 clear-all irq", irq, 1'b0);
    wr(8'h20, 32'h2);
    rdchk("R7 nack cleared", 8'h20, 0);
    ev_done = 1'b1; wr(8'h20, 32'h1); ev_done = 1'b0;
    rdchk("R7 set beats clear", 8'h20, 32'h1);

    // R8 status flags
    wr(8'h08, 0);
    ev_buserr = 1'b1; ev_arblost = 1'b1; @(negedge clk); ev_buserr = 1'b0; ev_arblost = 1'b0;
    ev_busy = 1'b1;
    rdchk("R8 flags", 8'h08, 32'h4A);
    wr(8'h08, 32'h2);
    rdchk("R8 w1c bus error", 8'h08, 32'h48);
    wr(8'h08, 32'h8);
    rdchk("R8 arb not w1c", 8'h08, 32'h48);
    ev_busy = 1'b0;
    rdchk("R8 busy live", 8'h08, 32'h08);
    wr(8'h08, 0);
    rdchk("R8 write zero", 8'h08, 0);

    // R9 no irq without enable
    wr(8'h00, 32'h80);
    ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
    chk("R9 ien off", irq, 1'b0);
    rdchk("R9 pending still set", 8'h08, 32'h4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule